// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical address issued by a small one-address processor into a physical address. Each process owns two separate 64 KB logical spaces, one for instruction fetches and one for data, each cut into 32 pages of 2 KB. The page table for a process is 64 words of 16 bits. It sits in a dedicated on-chip table memory that holds one such table for every process slot. A base register, loaded only under a privileged strobe, selects the active table.

A request presents the address, a code-or-data select and a read-or-write flag. One clock later the block drives either a memory strobe with a 22-bit physical address and a device-space flag, or a one-cycle fault. Supervisor software fills the table through a separate write port. That port may be used in the same cycle as a lookup.

Top module: `page_xlat`

## Requirements
- R1: The low 11 bits of the logical address appear unchanged as the low 11 bits of the physical address on every strobed result.
- R2: The table word used is at table address base*64 + {space, addr[15:11]}, where space is 0 for code (entries 0..31) and 1 for data (entries 32..63).
- R3: Table word layout: bit 15 valid, bit 14 writable, bit 13 device, bits 12:11 ignored, bits 10:0 frame. A strobed result drives physical address {frame, offset} and a device flag equal to bit 13.
- R4: A request that hits a word with valid=0 raises the fault output for exactly one cycle and leaves the strobe low.
- R5: A write request that hits a word with writable=0 faults and is not strobed. A read of the same word is strobed. On a strobed result, the write flag output repeats the request's write flag.
- R6: A result (strobe or fault) appears in the cycle after the request is sampled. Cycles with no request produce neither strobe nor fault.
- R7: When a table write targets the same table address that a lookup uses in the same cycle, the lookup result uses the newly written word.
- R8: The base register resets to 0. It changes only in a cycle where both the load strobe and the privilege input are high. A lookup in the same cycle as a load still uses the old base.
- R9: While reset is held, strobe, fault, write flag, device flag and physical address are all 0.
- R10: Whenever the strobe is low, the physical address, device flag and write flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_addr | input | 16 | Logical address |
| req_space | input | 1 | 0 = code, 1 = data |
| req_write | input | 1 | 1 = write access |
| tw_en | input | 1 | Table write enable |
| tw_addr | input | 9 | Absolute table address (base*64 + index) |
| tw_data | input | 16 | Table word to store |
| base_ld | input | 1 | Base register load strobe |
| base_priv | input | 1 | Privilege qualifier for base_ld |
| base_data | input | 3 | New base (process slot) |
| out_strobe | output | 1 | Memory strobe for a permitted access |
| out_fault | output | 1 | One-cycle fault for a refused access |
| out_write | output | 1 | Write flag of the strobed access |
| out_dev | output | 1 | Device-space select |
| out_paddr | output | 22 | Physical address {frame, offset} |

## Verification
A table write and a lookup can fall in the same cycle. When both hit one word, the lookup must see the new word. The bench provokes this by writing a valid entry into a word that was just cleared while looking it up, and again by clearing a valid word during its lookup. The first case must strobe with the new frame and the second must fault. A base load and a lookup can also coincide, and that lookup must still resolve through the old table. The scoreboard judges all of these from its own shadow copy of the tables and the base.

// File: rtl/page_xlat.sv
module page_xlat #(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 11,
  parameter int ENT_W   = 16,
  parameter int BASE_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [LA_W-1:0]            req_addr,
  input  logic                       req_space,
  input  logic                       req_write,
  input  logic                       tw_en,
  input  logic [BASE_W+LA_W-OFF_W:0] tw_addr,
  input  logic [ENT_W-1:0]           tw_data,
  input  logic                       base_ld,
  input  logic                       base_priv,
  input  logic [BASE_W-1:0]          base_data,
  output logic                       out_strobe,
  output logic                       out_fault,
  output logic                       out_write,
  output logic                       out_dev,
  output logic [FRAME_W+OFF_W-1:0]   out_paddr
);
  localparam int PG_W  = LA_W - OFF_W;
  localparam int TA_W  = BASE_W + PG_W + 1;
  localparam int DEPTH = 1 << TA_W;
  localparam int B_V   = ENT_W - 1;
  localparam int B_W   = ENT_W - 2;
  localparam int B_D   = ENT_W - 3;

  logic [ENT_W-1:0]  tbl [DEPTH];
  logic [ENT_W-1:0]  ent_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic              v_q, wr_q;
  logic [TA_W-1:0]   lk_addr;

  assign lk_addr = {base_q, req_space, req_addr[LA_W-1:OFF_W]};

  always_ff @(posedge clk) begin
    if (tw_en) tbl[tw_addr] <= tw_data;
    ent_q <= (tw_en && tw_addr == lk_addr) ? tw_data : tbl[lk_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      wr_q   <= 1'b0;
      off_q  <= '0;
      base_q <= '0;
    end else begin
      v_q   <= req_valid;
      wr_q  <= req_write;
      off_q <= req_addr[OFF_W-1:0];
      if (base_ld && base_priv) base_q <= base_data;
    end
  end

  logic allow;
  assign allow      = ent_q[B_V] && !(wr_q && !ent_q[B_W]);
  assign out_strobe = v_q && allow;
  assign out_fault  = v_q && !allow;
  assign out_write  = out_strobe && wr_q;
  assign out_dev    = out_strobe && ent_q[B_D];
  assign out_paddr  = out_strobe ? {ent_q[FRAME_W-1:0], off_q} : '0;
endmodule

module page_xlat_chk #(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 11,
  parameter int BASE_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [LA_W-1:0]          req_addr,
  input logic                     req_write,
  input logic                     base_ld,
  input logic                     base_priv,
  input logic [BASE_W-1:0]        base_q,
  input logic                     out_strobe,
  input logic                     out_fault,
  input logic                     out_write,
  input logic                     out_dev,
  input logic [FRAME_W+OFF_W-1:0] out_paddr
);
  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> out_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_strobe && out_fault));
  p_wflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> out_write == $past(req_write));
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe || out_fault) |-> $past(req_valid));
  p_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_ld && base_priv) |=> $stable(base_q));
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_strobe |-> (out_paddr == '0 && !out_dev && !out_write));
endmodule

bind page_xlat page_xlat_chk #(.LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .base_ld(base_ld), .base_priv(base_priv),
  .base_q(base_q), .out_strobe(out_strobe), .out_fault(out_fault),
  .out_write(out_write), .out_dev(out_dev), .out_paddr(out_paddr)
);

// File: tb/sim_page_xlat.sv
module sim_page_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_space = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        tw_en = 1'b0;
  logic [8:0]  tw_addr = '0;
  logic [15:0] tw_data = '0;
  logic        base_ld = 1'b0, base_priv = 1'b0;
  logic [2:0]  base_data = '0;
  logic        out_strobe, out_fault, out_write, out_dev;
  logic [21:0] out_paddr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] shadow [512];
  logic [2:0]  m_base = '0;
  logic [25:0] expq [$];
  string       tagq [$];

  always #10 clk = ~clk;

  page_xlat u0 (.*);

  task automatic step(input logic rv, input logic [15:0] a, input logic sp, input logic wr,
                      input logic twe, input logic [8:0] twa, input logic [15:0] twd,
                      input logic bl, input logic bp, input logic [2:0] bd, input string tag);
    logic [8:0]  idx;
    logic [15:0] e;
    logic        ok;
    @(negedge clk);
    req_valid = rv; req_addr = a; req_space = sp; req_write = wr;
    tw_en = twe; tw_addr = twa; tw_data = twd;
    base_ld = bl; base_priv = bp; base_data = bd;
    idx = {m_base, sp, a[15:11]};
    e   = (twe && twa == idx) ? twd : shadow[idx];
    ok  = rv && e[15] && !(wr && !e[14]);
    expq.push_back({ok, rv && !ok, ok && wr, ok && e[13], ok ? {e[10:0], a[10:0]} : 22'd0});
    tagq.push_back(tag);
    if (twe) shadow[twa] = twd;
    if (bl && bp) m_base = bd;
  endtask

  task automatic rd(input logic [15:0] a, input logic sp, input logic wr, input string tag);
    step(1'b1, a, sp, wr, 1'b0, 9'd0, 16'd0, 1'b0, 1'b0, 3'd0, tag);
  endtask

  task automatic wt(input logic [8:0] ta, input logic [15:0] d, input string tag);
    step(1'b0, 16'd0, 1'b0, 1'b0, 1'b1, ta, d, 1'b0, 1'b0, 3'd0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 9'd0, 16'd0, 1'b0, 1'b0, 3'd0, tag);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (expq.size() > 0) begin
      logic [25:0] e, g;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      g = {out_strobe, out_fault, out_write, out_dev, out_paddr};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got s=%b f=%b w=%b d=%b pa=%h, expected s=%b f=%b w=%b d=%b pa=%h",
                 t, g[25], g[24], g[23], g[22], g[21:0], e[25], e[24], e[23], e[22], e[21:0]);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({out_strobe, out_fault, out_write, out_dev, out_paddr} !== 26'd0) begin
      fails++;
      $display("FAIL R9: outputs during reset got %b expected 0",
               {out_strobe, out_fault, out_write, out_dev, out_paddr});
    end
    rst_n = 1'b1;
    for (int i = 0; i < 512; i++) wt(i[8:0], 16'h0000, "R6 idle while clearing");
    // R1 R3: code page 0, valid+writable, frame 0x123
    wt(9'd0, 16'hC123, "R6");
    rd(16'h0456, 1'b0, 1'b0, "R1 R3 code read");
    rd(16'h07FF, 1'b0, 1'b1, "R1 R5 code write allowed");
    // R2 R3: data page 3 (entry 35) valid, read-only, device, reserved bits set
    wt(9'd35, 16'hB9AB, "R6");
    wt(9'd3, 16'h8055, "R6");
    rd(16'h1ABC, 1'b1, 1'b0, "R2 R3 data page, device");
    rd(16'h1ABC, 1'b0, 1'b0, "R2 code page same address");
    rd(16'h1ABC, 1'b1, 1'b1, "R5 write to read-only faults");
    idle("R6 no request after fault");
    rd(16'h2000, 1'b0, 1'b0, "R4 invalid entry faults");
    rd(16'hF800, 1'b1, 1'b1, "R4 invalid data page 31");
    idle("R6 idle");
    // R7 collisions
    step(1'b1, 16'h2801, 1'b0, 1'b1, 1'b1, 9'd5, 16'hC7FF, 1'b0, 1'b0, 3'd0, "R7 write-through valid");
    rd(16'h2802, 1'b0, 1'b1, "R7 next cycle");
    step(1'b1, 16'h2803, 1'b0, 1'b0, 1'b1, 9'd5, 16'h47FF, 1'b0, 1'b0, 3'd0, "R7 invalidate same cycle");
    step(1'b1, 16'h2804, 1'b0, 1'b0, 1'b1, 9'd6, 16'hC001, 1'b0, 1'b0, 3'd0, "R7 other word no effect");
    // R8 base handling
    wt(9'd128, 16'hC2AA, "R6");
    step(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 9'd0, 16'd0, 1'b1, 1'b0, 3'd2, "R8 unprivileged load");
    rd(16'h0010, 1'b0, 1'b0, "R8 base still 0");
    step(1'b1, 16'h0020, 1'b0, 1'b0, 1'b0, 9'd0, 16'd0, 1'b1, 1'b1, 3'd2, "R8 lookup with old base");
    rd(16'h0030, 1'b0, 1'b0, "R8 new base 2");
    rd(16'h0030, 1'b1, 1'b0, "R4 R8 base 2 data empty");
    wt(9'd191, 16'hE3FF, "R6");
    rd(16'hFFFF, 1'b1, 1'b1, "R1 R2 last data page");
    idle("R10 idle");
    idle("R10 idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule